// File: doc/BRIEF.md
# USB Endpoint Control and Status Register

This block holds the control and status state of a single USB endpoint that can be used for IN or OUT traffic. It sits between the USB packet engine and the CPU bus. The CPU sees one 32-bit register with a single-cycle write strobe and a combinational read value. The packet engine signals when it has loaded an OUT packet into the endpoint FIFO, whether that packet was corrupted, and when an IN packet has been sent. The CPU side reports each FIFO write beat with its byte count.

For OUT traffic the block keeps a queue of up to two packets. Each entry carries its own error flag, so the error bit the CPU sees always belongs to the packet it is about to unload. The queue depth is one packet or two. It is two when the configured maximum packet size fits in half of the FIFO. If a packet arrives while the queue is full, it is dropped. In isochronous mode that drop is recorded in a sticky overrun flag. For IN traffic the block counts the bytes the CPU writes. When auto-set is enabled, it raises IN-ready by itself once exactly one maximum-size packet has been written.

Top module: `usb_ep_csr`

## Requirements
- R1: After reset every bit of `reg_rdata` is 0.
- R2: A register write with bit 15 of the write data at 0 leaves read bits 12:8 unchanged. Read bit 15 then reads 0.
- R3: A register write with bit 15 at 1 loads bit 12 (auto-set enable) and bit 8 (IN-ready) from the write data. Read bit 15 then reads 1. Bits 11:9 always read 0.
- R4: In IN mode with auto-set enabled, bit 8 rises in the cycle after the FIFO byte count since the last sent packet reaches exactly `max_pkt`. `usb_in_sent` clears bit 8 and the count.
- R5: If fewer than `max_pkt` bytes have been written, bit 8 stays 0 until the CPU sets it with a write that has bit 15 at 1.
- R6: In OUT mode bit 16 (packet ready) is set when a packet is loaded. With two-packet depth, the pair {bit 17, bit 16} reads 01 for one queued packet and 11 for two.
- R7: When `max_pkt` exceeds half of `FIFO_BYTES`, the depth is one packet, so a single queued packet reads {bit 17, bit 16} = 11.
- R8: The CPU unloads a packet by writing 0 to bit 16 while it is set. Bit 16 then reads 0 for one cycle. If another packet is queued, bit 16 returns to 1 in the cycle after.
- R9: In isochronous OUT mode, bit 19 shows the error flag of the head packet only. The flag of a second packet appears only after the first has been unloaded.
- R10: Bit 19 reads 0 whenever bit 16 reads 0. Bit 19 also reads 0 outside isochronous mode.
- R11: A packet loaded while the queue is full is dropped and changes no queue state. In isochronous mode the drop sets bit 18. Bit 18 stays set until the CPU writes 0 to it.
- R12: In IN mode, bits 19:16 read 0 and load strobes are ignored. In OUT mode, FIFO write beats do not advance the auto-set count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| ep_dir_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| ep_iso | input | 1 | 1 = isochronous transfers |
| max_pkt | input | MPS_W | Maximum packet size in bytes |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read value |
| cpu_fifo_wr | input | 1 | CPU FIFO write beat |
| cpu_fifo_bytes | input | BW | Bytes written in this beat |
| usb_pkt_loaded | input | 1 | Packet engine finished loading an OUT packet |
| usb_pkt_err | input | 1 | Bit-stuffing or CRC error on that packet |
| usb_in_sent | input | 1 | IN packet sent; clears IN-ready |

## Verification
Some properties are checked on every cycle. The OUT bits are zero in IN mode. The error bit requires packet ready, and the full bit requires packet ready. The overrun flag is sticky. A write with the mask bit at 0 preserves bits 12:8, and a write with the mask bit at 1 loads bits 12 and 8. Other behaviour can only be shown by the bench's scenarios:
- the one-cycle gap after an unload,
- the hand-over of the second packet's error flag,
- the dropping of a packet into a full queue at both depths,
- the exact-count auto-set against a short packet.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  localparam int unsigned B_IN_RDY = 8;
  localparam int unsigned B_AUTO   = 12;
  localparam int unsigned B_WMASK  = 15;
  localparam int unsigned B_ORDY   = 16;
  localparam int unsigned B_OFULL  = 17;
  localparam int unsigned B_OOVR   = 18;
  localparam int unsigned B_OERR   = 19;
  localparam int unsigned QDEPTH   = 2;

  typedef struct packed {
    logic err;
    logic ovr;
    logic full;
    logic rdy;
  } out_stat_t;
endpackage

// File: rtl/usb_ep_out_queue.sv
module usb_ep_out_queue #(
  parameter int unsigned FIFO_BYTES = 64,
  parameter int unsigned MPS_W      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             iso,
  input  logic [MPS_W-1:0] max_pkt,
  input  logic             load,
  input  logic             load_err,
  input  logic             pop,
  input  logic             ovr_clr,
  output usb_ep_pkg::out_stat_t stat,
  output logic             ovr_flag
);
  localparam int unsigned HALF = FIFO_BYTES / 2;
  localparam int unsigned QD   = usb_ep_pkg::QDEPTH;

  logic [1:0]  qcnt_q, qcnt_n;
  logic        rdy_q, rdy_n;
  logic        ovr_q, ovr_n;
  logic [QD-1:0] err_q, err_n, err_shift;
  logic [1:0]  depth_lim, cnt_after_pop;
  logic        pop_ok, accept, drop;

  // two-packet depth only when a maximum packet fits in half the FIFO
  assign depth_lim     = (max_pkt <= MPS_W'(HALF)) ? 2'd2 : 2'd1;
  assign pop_ok        = pop & rdy_q;
  assign cnt_after_pop = qcnt_q - {1'b0, pop_ok};
  assign accept        = en & load & (cnt_after_pop < depth_lim);
  assign drop          = en & load & ~accept;

  // shift the error flags toward the head on an unload
  generate
    for (genvar i = 0; i < QD; i++) begin : g_shift
      if (i == QD - 1) begin : g_tail
        assign err_shift[i] = pop_ok ? 1'b0 : err_q[i];
      end else begin : g_body
        assign err_shift[i] = pop_ok ? err_q[i+1] : err_q[i];
      end
    end
  endgenerate

  always_comb begin
    qcnt_n = cnt_after_pop + {1'b0, accept};
    err_n  = err_shift;
    if (accept) begin
      err_n[cnt_after_pop[0]] = load_err;
    end
    if (pop_ok) begin
      rdy_n = 1'b0;
    end else begin
      rdy_n = (qcnt_n != 2'd0);
    end
    if (drop && iso) begin
      ovr_n = 1'b1;
    end else if (ovr_clr) begin
      ovr_n = 1'b0;
    end else begin
      ovr_n = ovr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcnt_q <= 2'd0;
      rdy_q  <= 1'b0;
      ovr_q  <= 1'b0;
      err_q  <= '0;
    end else begin
      qcnt_q <= qcnt_n;
      rdy_q  <= rdy_n;
      ovr_q  <= ovr_n;
      err_q  <= err_n;
    end
  end

  assign stat.rdy  = rdy_q;
  assign stat.full = rdy_q & (qcnt_q == depth_lim);
  assign stat.ovr  = ovr_q;
  assign stat.err  = rdy_q & err_q[0];
  assign ovr_flag  = ovr_q;
endmodule

// File: rtl/usb_ep_in_ctrl.sv
module usb_ep_in_ctrl #(
  parameter int unsigned MPS_W = 7,
  parameter int unsigned BW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_in,
  input  logic             ctl_wr,
  input  logic             wr_auto,
  input  logic             wr_rdy,
  input  logic             fifo_wr,
  input  logic [BW-1:0]    fifo_bytes,
  input  logic [MPS_W-1:0] max_pkt,
  input  logic             pkt_sent,
  output logic             auto_en,
  output logic             in_rdy
);
  localparam int unsigned CW = MPS_W + 1;

  logic [CW-1:0] cnt_q, cnt_n;
  logic [CW:0]   sum;
  logic          auto_q, auto_n, rdy_q, rdy_n, hit, cnt_en;

  assign sum    = {1'b0, cnt_q} + (CW+1)'(fifo_bytes);
  assign cnt_en = en_in & fifo_wr;
  assign hit    = cnt_en & auto_q & (sum == (CW+1)'(max_pkt));

  always_comb begin
    cnt_n = cnt_q;
    if (pkt_sent) begin
      cnt_n = '0;
    end else if (cnt_en) begin
      cnt_n = sum[CW] ? '1 : sum[CW-1:0];
    end
    if (pkt_sent) begin
      rdy_n = 1'b0;
    end else if (ctl_wr) begin
      rdy_n = wr_rdy | hit;
    end else begin
      rdy_n = rdy_q | hit;
    end
    auto_n = ctl_wr ? wr_auto : auto_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rdy_q  <= 1'b0;
      auto_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      rdy_q  <= rdy_n;
      auto_q <= auto_n;
    end
  end

  assign auto_en = auto_q;
  assign in_rdy  = rdy_q;
endmodule

// File: rtl/usb_ep_csr.sv
module usb_ep_csr #(
  parameter int unsigned FIFO_BYTES = 64,
  parameter int unsigned MPS_W      = 7,
  parameter int unsigned BW         = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ep_dir_in,
  input  logic             ep_iso,
  input  logic [MPS_W-1:0] max_pkt,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             cpu_fifo_wr,
  input  logic [BW-1:0]    cpu_fifo_bytes,
  input  logic             usb_pkt_loaded,
  input  logic             usb_pkt_err,
  input  logic             usb_in_sent
);
  import usb_ep_pkg::*;

  logic      wmask_q, wmask_n;
  logic      ctl_wr, out_pop, out_ovr_clr, out_en;
  logic      auto_en, in_rdy, out_ovr;
  out_stat_t ostat;

  assign out_en      = ~ep_dir_in;
  assign ctl_wr      = reg_wr & reg_wdata[B_WMASK];
  assign out_pop     = reg_wr & out_en & ~reg_wdata[B_ORDY];
  assign out_ovr_clr = reg_wr & out_en & ~reg_wdata[B_OOVR];

  always_comb begin
    wmask_n = reg_wr ? reg_wdata[B_WMASK] : wmask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wmask_q <= 1'b0;
    end else begin
      wmask_q <= wmask_n;
    end
  end

  usb_ep_out_queue #(.FIFO_BYTES(FIFO_BYTES), .MPS_W(MPS_W)) u_outq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (out_en),
    .iso      (ep_iso),
    .max_pkt  (max_pkt),
    .load     (usb_pkt_loaded),
    .load_err (usb_pkt_err),
    .pop      (out_pop),
    .ovr_clr  (out_ovr_clr),
    .stat     (ostat),
    .ovr_flag (out_ovr)
  );

  usb_ep_in_ctrl #(.MPS_W(MPS_W), .BW(BW)) u_inc (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_in      (ep_dir_in),
    .ctl_wr     (ctl_wr),
    .wr_auto    (reg_wdata[B_AUTO]),
    .wr_rdy     (reg_wdata[B_IN_RDY]),
    .fifo_wr    (cpu_fifo_wr),
    .fifo_bytes (cpu_fifo_bytes),
    .max_pkt    (max_pkt),
    .pkt_sent   (usb_in_sent),
    .auto_en    (auto_en),
    .in_rdy     (in_rdy)
  );

  always_comb begin
    reg_rdata           = '0;
    reg_rdata[B_IN_RDY] = in_rdy;
    reg_rdata[B_AUTO]   = auto_en;
    reg_rdata[B_WMASK]  = wmask_q;
    reg_rdata[B_ORDY]   = out_en & ostat.rdy;
    reg_rdata[B_OFULL]  = out_en & ostat.full;
    reg_rdata[B_OOVR]   = out_en & ep_iso & ostat.ovr;
    reg_rdata[B_OERR]   = out_en & ep_iso & ostat.err;
  end
endmodule

// File: rtl/usb_ep_csr_chk.sv
module usb_ep_csr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ep_dir_in,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        cpu_fifo_wr,
  input logic        usb_in_sent,
  input logic        ovr_flag
);
  a_r12_in_mode_out_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ep_dir_in |-> (reg_rdata[19:16] == 4'd0));

  a_r10_err_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[16] |-> !reg_rdata[19]);

  a_r6_full_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[17] |-> reg_rdata[16]);

  a_r2_masked_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_wdata[15] && !cpu_fifo_wr && !usb_in_sent)
      |=> (reg_rdata[12:8] == $past(reg_rdata[12:8])));

  a_r3_unmasked_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[15] && !cpu_fifo_wr && !usb_in_sent)
      |=> (reg_rdata[12] == $past(reg_wdata[12])) && (reg_rdata[8] == $past(reg_wdata[8]))
          && reg_rdata[15]);

  a_r11_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !(reg_wr && !ep_dir_in && !reg_wdata[18])) |=> ovr_flag);
endmodule

bind usb_ep_csr usb_ep_csr_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ep_dir_in   (ep_dir_in),
  .reg_wr      (reg_wr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .cpu_fifo_wr (cpu_fifo_wr),
  .usb_in_sent (usb_in_sent),
  .ovr_flag    (out_ovr)
);

// File: tb/test_usb_ep_csr.sv
module test_usb_ep_csr;
  localparam logic [31:0] OUTM = 32'h000F_0000;
  localparam logic [31:0] INM  = 32'h0000_FF00;

  logic        clk, rst_n, ep_dir_in, ep_iso, reg_wr, cpu_fifo_wr;
  logic        usb_pkt_loaded, usb_pkt_err, usb_in_sent;
  logic [6:0]  max_pkt;
  logic [31:0] reg_wdata, reg_rdata;
  logic [2:0]  cpu_fifo_bytes;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] q_mask[$];
  logic [31:0] q_val[$];
  string       q_tag[$];

  usb_ep_csr i_usb_ep_csr (
    .clk(clk), .rst_n(rst_n), .ep_dir_in(ep_dir_in), .ep_iso(ep_iso),
    .max_pkt(max_pkt), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_fifo_wr(cpu_fifo_wr), .cpu_fifo_bytes(cpu_fifo_bytes),
    .usb_pkt_loaded(usb_pkt_loaded), .usb_pkt_err(usb_pkt_err), .usb_in_sent(usb_in_sent)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // monitor: pops expected items and compares after the inputs settle
  always @(negedge clk) begin
    #2;
    while (q_val.size() > 0) begin
      logic [31:0] m, v;
      string t;
      m = q_mask.pop_front();
      v = q_val.pop_front();
      t = q_tag.pop_front();
      checks++;
      if ((reg_rdata & m) !== v) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", t, reg_rdata & m, v);
      end
    end
  end

  task automatic expect_rd(input logic [31:0] m, input logic [31:0] v, input string t);
    q_mask.push_back(m);
    q_val.push_back(v);
    q_tag.push_back(t);
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic load(input logic e);
    @(negedge clk); usb_pkt_loaded = 1'b1; usb_pkt_err = e;
    @(negedge clk); usb_pkt_loaded = 1'b0; usb_pkt_err = 1'b0;
  endtask

  task automatic fifo(input logic [2:0] n);
    @(negedge clk); cpu_fifo_wr = 1'b1; cpu_fifo_bytes = n;
    @(negedge clk); cpu_fifo_wr = 1'b0; cpu_fifo_bytes = '0;
  endtask

  task automatic sent();
    @(negedge clk); usb_in_sent = 1'b1;
    @(negedge clk); usb_in_sent = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ep_dir_in = 1'b0; ep_iso = 1'b1; max_pkt = 7'd16;
    reg_wr = 1'b0; reg_wdata = '0; cpu_fifo_wr = 1'b0; cpu_fifo_bytes = '0;
    usb_pkt_loaded = 1'b0; usb_pkt_err = 1'b0; usb_in_sent = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    expect_rd(32'hFFFF_FFFF, 32'h0, "R1 reset value");

    // isochronous OUT, two-packet depth
    load(1'b0);             expect_rd(OUTM, 32'h0001_0000, "R6 one packet");
    load(1'b1);             expect_rd(OUTM, 32'h0003_0000, "R6 R9 two packets, head clean");
    load(1'b0);             expect_rd(OUTM, 32'h0007_0000, "R11 overrun on full");
    wr(32'h0004_0000);      expect_rd(OUTM, 32'h0004_0000, "R8 R10 gap after unload");
    step();                 expect_rd(OUTM, 32'h000D_0000, "R9 second packet error shown");
    wr(32'h0000_0000);      expect_rd(OUTM, 32'h0, "R11 overrun cleared by write 0");
    step();                 expect_rd(OUTM, 32'h0, "R11 dropped packet not queued");

    // non-isochronous OUT
    ep_iso = 1'b0;
    load(1'b1);             expect_rd(OUTM, 32'h0001_0000, "R10 error hidden outside iso");
    load(1'b0);             expect_rd(OUTM, 32'h0003_0000, "R6 two packets non-iso");
    load(1'b0);             expect_rd(OUTM, 32'h0003_0000, "R11 no overrun outside iso");
    wr(32'h0);              expect_rd(OUTM, 32'h0, "R8 unload gap");
    step();                 expect_rd(OUTM, 32'h0001_0000, "R8 ready returns");
    wr(32'h0);              step(); expect_rd(OUTM, 32'h0, "R8 queue empty");

    // isochronous OUT, one-packet depth
    ep_iso = 1'b1; max_pkt = 7'd48;
    load(1'b1);             expect_rd(OUTM, 32'h000B_0000, "R7 R9 single packet full with error");
    load(1'b0);             expect_rd(OUTM, 32'h000F_0000, "R7 R11 overrun at depth one");
    wr(32'h0);              expect_rd(OUTM, 32'h0, "R10 error clears with ready");
    step();                 expect_rd(OUTM, 32'h0, "R7 dropped packet not queued");

    // IN mode
    ep_dir_in = 1'b1; max_pkt = 7'd16;
    load(1'b0);             expect_rd(OUTM, 32'h0, "R12 load ignored in IN mode");
    wr(32'h0000_1100);      expect_rd(INM, 32'h0, "R2 masked write ignored");
    wr(32'h0000_9F00);      expect_rd(INM, 32'h9100, "R3 unmasked write loads");
    wr(32'h0000_0000);      expect_rd(INM, 32'h1100, "R2 masked write keeps 12:8");
    sent();                 expect_rd(INM, 32'h1000, "R4 sent clears ready");
    fifo(3'd4); fifo(3'd4); fifo(3'd4);
                            expect_rd(INM, 32'h1000, "R4 not yet full packet");
    fifo(3'd4);             expect_rd(INM, 32'h1100, "R4 auto-set at max");
    sent();                 expect_rd(INM, 32'h1000, "R4 sent clears again");
    fifo(3'd4); fifo(3'd4); expect_rd(INM, 32'h1000, "R5 short packet no auto-set");
    wr(32'h0000_9100);      expect_rd(INM, 32'h9100, "R5 CPU sets ready");
    sent();                 expect_rd(INM, 32'h9000, "R4 sent clears ready");

    // auto-set has no effect in OUT mode
    ep_dir_in = 1'b0;
    fifo(3'd4); fifo(3'd4); fifo(3'd4); fifo(3'd4);
                            expect_rd(INM, 32'h9000, "R12 no auto-set in OUT mode");
    step(); step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule